// File: doc/BRIEF.md
# Keyed Command Sequence Detector

This block sits behind the mode decoder of a nonvolatile-backed memory and watches only the command-write strobes it receives. Each strobe comes with an address and a data byte. Commands are guarded by a two-step key. The first write must carry address 0x555 with data 0xAA. The second must carry address 0x2AA with data 0x55. A third write to address 0x555 then carries a code byte that selects the action.

One code asks the transfer sequencer to copy the whole RAM into the nonvolatile array at once. The two other codes set or clear a persistent enable latch. That latch arms the automatic save on supply loss, and its level is driven to the transfer sequencer. The power-on reset input returns the sequencer to idle and clears the latch.

Ordinary RAM reads and writes never reach this block as command strobes, so they cannot advance or break a sequence. Writes that do not follow the key restart it. This makes it very unlikely that stray traffic triggers a store.

Top module: `cmd_seq_det`

## Requirements
- R1: While rst_ni is low, and after it is released, store_req_o and auto_en_o are 0 and the sequencer is idle, so a lone third-step write has no effect.
- R2: An action is taken only after three command writes in order: 0x555/0xAA, then 0x2AA/0x55, then a write to 0x555.
- R3: Third-step data 0x33 raises store_req_o for exactly one cycle, in the cycle after the clock edge that samples that write.
- R4: Third-step data 0xCC sets auto_en_o from the cycle after the write, and it stays set as a level.
- R5: Third-step data 0xCD clears auto_en_o from the cycle after the write.
- R6: A third-step write to 0x555 whose data is none of 0x33, 0xCC, 0xCD or 0xAA takes no action and returns the sequencer to idle.
- R7: A command write that does not match the expected step returns the sequencer to idle. If that write is 0x555/0xAA, the sequencer instead counts it as the first key step.
- R8: Cycles with cmd_wr_i low leave the sequencer state and both outputs unchanged, whatever the address and data.
- R9: The store code leaves auto_en_o unchanged, and the latch codes never raise store_req_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cmd_wr_i | input | 1 | Command-write strobe from the mode decoder, one cycle per write |
| addr_i | input | ADDR_W (11) | Address of the command write |
| data_i | input | DATA_W (8) | Data of the command write |
| store_req_o | output | 1 | Single-cycle software store request |
| auto_en_o | output | 1 | Automatic-store enable latch level |

## Verification
The bench builds the block with its default parameters: an 11-bit address, an 8-bit data byte, and the key and code values given above. At these widths, near-miss writes are in reach. These include a key address with the wrong data byte, a code one step off the clear code, and the first key replayed in either intermediate state. Address and data noise between key steps, with the strobe low, shows that only strobed writes move the sequence. A reset in the middle of a sequence shows that the partial key is lost together with the latch.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY1 = 2'd1,
    ST_KEY2 = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_STORE = 2'd1,
    ACT_AEN   = 2'd2,
    ACT_ADIS  = 2'd3
  } seq_act_e;

  typedef struct packed {
    logic key1;
    logic key2;
    logic cmd_addr;
    logic c_store;
    logic c_aen;
    logic c_adis;
  } step_hits_t;
endpackage

// File: rtl/cmd_step_match.sv
module cmd_step_match
  import cmd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 11'h555,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 11'h2AA,
  parameter logic [DATA_W-1:0] KEY2_DATA = 8'h55,
  parameter logic [DATA_W-1:0] CODE_STORE = 8'h33,
  parameter logic [DATA_W-1:0] CODE_AEN   = 8'hCC,
  parameter logic [DATA_W-1:0] CODE_ADIS  = 8'hCD
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output step_hits_t        hits_o
);
  logic a1, a2;

  assign a1 = (addr_i == KEY1_ADDR);
  assign a2 = (addr_i == KEY2_ADDR);

  always_comb begin
    hits_o          = '0;
    hits_o.key1     = a1 && (data_i == KEY1_DATA);
    hits_o.key2     = a2 && (data_i == KEY2_DATA);
    // third step shares the first key address
    hits_o.cmd_addr = a1;
    hits_o.c_store  = (data_i == CODE_STORE);
    hits_o.c_aen    = (data_i == CODE_AEN);
    hits_o.c_adis   = (data_i == CODE_ADIS);
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  step_hits_t hits_i,
  output seq_state_e state_o,
  output seq_act_e   act_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    act_o   = ACT_NONE;
    if (wr_i) begin
      state_d = hits_i.key1 ? ST_KEY1 : ST_IDLE;
      unique case (state_q)
        ST_KEY1: if (hits_i.key2) state_d = ST_KEY2;
        ST_KEY2: begin
          if (hits_i.cmd_addr) begin
            if      (hits_i.c_store) act_o = ACT_STORE;
            else if (hits_i.c_aen)   act_o = ACT_AEN;
            else if (hits_i.c_adis)  act_o = ACT_ADIS;
          end
          if (act_o != ACT_NONE) state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cmd_action_reg.sv
module cmd_action_reg
  import cmd_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seq_act_e act_i,
  output logic     store_req_o,
  output logic     auto_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_req_o <= 1'b0;
      auto_en_o   <= 1'b0;
    end else begin
      store_req_o <= (act_i == ACT_STORE);
      if (act_i == ACT_AEN)       auto_en_o <= 1'b1;
      else if (act_i == ACT_ADIS) auto_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_seq_det.sv
module cmd_seq_det
  import cmd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 11'h555,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 11'h2AA,
  parameter logic [DATA_W-1:0] KEY2_DATA = 8'h55,
  parameter logic [DATA_W-1:0] CODE_STORE = 8'h33,
  parameter logic [DATA_W-1:0] CODE_AEN   = 8'hCC,
  parameter logic [DATA_W-1:0] CODE_ADIS  = 8'hCD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              store_req_o,
  output logic              auto_en_o
);
  step_hits_t hits;
  seq_state_e state;
  seq_act_e   act;

  cmd_step_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY1_ADDR(KEY1_ADDR), .KEY1_DATA(KEY1_DATA),
    .KEY2_ADDR(KEY2_ADDR), .KEY2_DATA(KEY2_DATA),
    .CODE_STORE(CODE_STORE), .CODE_AEN(CODE_AEN), .CODE_ADIS(CODE_ADIS)
  ) u_match (
    .addr_i(addr_i),
    .data_i(data_i),
    .hits_o(hits)
  );

  cmd_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd_wr_i),
    .hits_i (hits),
    .state_o(state),
    .act_o  (act)
  );

  cmd_action_reg u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .store_req_o(store_req_o),
    .auto_en_o  (auto_en_o)
  );
endmodule

// File: rtl/cmd_seq_det_chk.sv
module cmd_seq_det_chk
  import cmd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 11'h555,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_STORE = 8'h33,
  parameter logic [DATA_W-1:0] CODE_AEN   = 8'hCC,
  parameter logic [DATA_W-1:0] CODE_ADIS  = 8'hCD
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              store_req_o,
  input logic              auto_en_o,
  input seq_state_e        state_i
);
  // R3
  store_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);

  // R3
  store_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $past(cmd_wr_i && addr_i == KEY1_ADDR && data_i == CODE_STORE));

  // R4
  aen_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auto_en_o) |-> $past(cmd_wr_i && addr_i == KEY1_ADDR && data_i == CODE_AEN));

  // R5
  aen_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(auto_en_o) |-> $past(cmd_wr_i && addr_i == KEY1_ADDR && data_i == CODE_ADIS));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i |=> $stable(state_i) && $stable(auto_en_o) && !store_req_o);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && addr_i == KEY1_ADDR && data_i == KEY1_DATA) |=> state_i == ST_KEY1);

  // R9
  store_keeps_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $stable(auto_en_o));
endmodule

bind cmd_seq_det cmd_seq_det_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY1_ADDR(KEY1_ADDR), .KEY1_DATA(KEY1_DATA),
  .CODE_STORE(CODE_STORE), .CODE_AEN(CODE_AEN), .CODE_ADIS(CODE_ADIS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr_i),
  .addr_i(addr_i), .data_i(data_i),
  .store_req_o(store_req_o), .auto_en_o(auto_en_o),
  .state_i(state)
);

// File: tb/cmd_seq_det_test.sv
module cmd_seq_det_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  data = '0;
  logic        store_req_o, auto_en_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmd_seq_det uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr),
    .addr_i(addr), .data_i(data),
    .store_req_o(store_req_o), .auto_en_o(auto_en_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one strobed write; sample the pulse in the cycle after the edge
  task automatic wr(input logic [10:0] a, input logic [7:0] d, output logic pulse);
    @(negedge clk); cmd_wr = 1'b1; addr = a; data = d;
    @(negedge clk); cmd_wr = 1'b0; addr = '0; data = '0;
    pulse = store_req_o;
  endtask

  task automatic seq3(input logic [7:0] code, output logic pulse);
    logic p;
    wr(11'h555, 8'hAA, p);
    wr(11'h2AA, 8'h55, p);
    wr(11'h555, code, pulse);
  endtask

  task automatic t_reset;
    logic p;
    chk("R1 store after reset", store_req_o, 1'b0);
    chk("R1 latch after reset", auto_en_o, 1'b0);
    wr(11'h555, 8'h33, p);
    chk("R1 lone third step", p, 1'b0);
  endtask

  task automatic t_store;
    logic p;
    wr(11'h555, 8'hAA, p);
    chk("R2 no pulse after key1", p, 1'b0);
    wr(11'h2AA, 8'h55, p);
    chk("R2 no pulse after key2", p, 1'b0);
    wr(11'h555, 8'h33, p);
    chk("R3 store pulse", p, 1'b1);
    chk("R9 store leaves latch", auto_en_o, 1'b0);
    @(negedge clk);
    chk("R3 pulse one cycle", store_req_o, 1'b0);
  endtask

  task automatic t_latch;
    logic p;
    seq3(8'hCC, p);
    chk("R4 latch set", auto_en_o, 1'b1);
    chk("R9 set gives no pulse", p, 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 latch held", auto_en_o, 1'b1);
    seq3(8'h33, p);
    chk("R9 store keeps latch set", auto_en_o, 1'b1);
    seq3(8'hCD, p);
    chk("R5 latch cleared", auto_en_o, 1'b0);
    chk("R9 clear gives no pulse", p, 1'b0);
  endtask

  task automatic t_bad_code;
    logic p;
    seq3(8'hCC, p);
    seq3(8'h12, p);
    chk("R6 unknown code no pulse", p, 1'b0);
    chk("R6 unknown code latch kept", auto_en_o, 1'b1);
    wr(11'h555, 8'hCD, p);
    chk("R6 back to idle", auto_en_o, 1'b1);
    seq3(8'hCE, p);
    chk("R6 near clear code", auto_en_o, 1'b1);
    seq3(8'hCD, p);
    chk("R5 clear after noise", auto_en_o, 1'b0);
  endtask

  task automatic t_mismatch;
    logic p;
    wr(11'h555, 8'hAA, p); wr(11'h2AA, 8'h54, p); wr(11'h555, 8'h33, p);
    chk("R7 bad key2 data", p, 1'b0);
    wr(11'h555, 8'hAA, p); wr(11'h2AA, 8'h55, p); wr(11'h123, 8'h33, p);
    chk("R7 bad third addr", p, 1'b0);
    wr(11'h555, 8'hAA, p); wr(11'h2AB, 8'h55, p); wr(11'h2AA, 8'h55, p);
    wr(11'h555, 8'h33, p);
    chk("R7 bad key2 addr resets", p, 1'b0);
    wr(11'h555, 8'hAA, p); wr(11'h555, 8'hAA, p); wr(11'h2AA, 8'h55, p);
    wr(11'h555, 8'h33, p);
    chk("R7 key1 replay in step one", p, 1'b1);
    wr(11'h555, 8'hAA, p); wr(11'h2AA, 8'h55, p); wr(11'h555, 8'hAA, p);
    wr(11'h2AA, 8'h55, p); wr(11'h555, 8'h33, p);
    chk("R7 key1 replay in step two", p, 1'b1);
  endtask

  task automatic t_ram_noise;
    logic p;
    wr(11'h555, 8'hAA, p);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); addr = (i[0]) ? 11'h555 : 11'h7FF; data = (i[1]) ? 8'h33 : 8'hCC;
    end
    @(negedge clk);
    chk("R8 no pulse while strobe low", store_req_o, 1'b0);
    chk("R8 latch steady while strobe low", auto_en_o, 1'b0);
    wr(11'h2AA, 8'h55, p);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); addr = 11'h100; data = 8'h00;
    end
    wr(11'h555, 8'h33, p);
    chk("R8 sequence survives idle cycles", p, 1'b1);
  endtask

  task automatic t_por;
    logic p;
    seq3(8'hCC, p);
    wr(11'h555, 8'hAA, p); wr(11'h2AA, 8'h55, p);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R1 reset clears latch", auto_en_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    wr(11'h555, 8'h33, p);
    chk("R1 reset drops partial key", p, 1'b0);
    chk("R1 latch stays clear", auto_en_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_store();
    t_latch();
    t_bad_code();
    t_mismatch();
    t_ram_noise();
    t_por();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule